// File: doc/BRIEF.md
# Two-Stage Fixed-Point Low-Pass Biquad Cascade

This block filters a stream of signed samples through a fourth-order low-pass response. The response comes from two second-order sections in series. Each accepted input sample produces exactly one filtered output sample. The input is a 12-bit two's-complement value qualified by a one-cycle strobe. The result is a 16-bit two's-complement value qualified by its own one-cycle pulse. The pulse arrives a fixed two clocks after the strobe, whatever the data, so a converter feeding the block and a converter draining it can both run on the same sample tick without jitter.

Coefficients are constants in Q14 format (unity equals 16384), and they are set through parameters at build time. Each section has a symmetric numerator. The stored output history of the first section also serves as the input history of the second section, so only one copy of that history is kept. Each section's accumulator is scaled back to sample scale by an arithmetic right shift of 14. The result is then clamped to the 16-bit range before it enters any history or leaves the block.

Strobes may arrive on consecutive clocks or with idle gaps of any length. Idle clocks leave every stored value untouched.

Top module: `biquad_cascade`

## Requirements
- R1: Section one computes acc = 88·x[n] + 176·x[n-1] + 88·x[n-2] − (−28286)·u[n-1] − 12253·u[n-2]. The feedback terms are subtracted, x is the sign-extended input and u is the section's own output history.
- R2: Section two takes section one's output u as its input and computes acc = 95·u[n] + 190·u[n-1] + 95·u[n-2] − (−30541)·w[n-1] − 14537·w[n-2]. Its result w[n] is the block output.
- R3: Each section output equals floor(acc / 2^14), an arithmetic right shift of a 32-bit signed accumulator, before saturation.
- R4: Each section output saturates to the range [−32768, 32767] instead of wrapping. The saturated value is the one stored in the history and driven out.
- R5: out_valid is a one-cycle pulse exactly two rising edges after each sampled in_valid. Back-to-back strobes give back-to-back pulses, and no pulse appears without a strobe.
- R6: On clocks where in_valid is low, no history changes, and out_sample holds the last result until the next pulse.
- R7: Synchronous active-high reset clears all histories and drives out_valid and out_sample to 0. After reset the filter behaves as if it had never seen input.
- R8: With only zero-valued input strobes after reset, out_sample stays exactly 0.
- R9: in_sample is two's complement. The values −2048 and 2047 are sign-extended before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: in_sample is accepted on this edge |
| in_sample | input | IN_W (12) | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_sample | output | 16 | Signed filtered result, held between pulses |

## Verification
The bench compares two builds against a behavioural integer model on every clock.

**Default build.** It is driven with:
- an impulse;
- full-scale steps of both signs;
- an alternating full-scale pattern at the highest input frequency;
- pseudo-random data with idle gaps.

A design that added the feedback terms instead of subtracting them would diverge within a few samples. A design that rounded instead of floored, or shifted logically, would be off by one on negative values. A design that advanced a history on an idle clock would corrupt every later result.

**High-gain build.** It drives both sections into the clamp. A wrapping design would flip sign at full scale.

**Reset and latency.** A reset in the middle of the run, followed by an impulse, exposes any history that survives reset. Checking the pulse on every clock catches latency that slips or depends on the data.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 32;
  localparam int FRAC_W = 14;
  localparam int SMAX   = 2 ** (DATA_W - 1) - 1;
  localparam int SMIN   = -(2 ** (DATA_W - 1));

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // arithmetic shift back to sample scale, then clamp
  function automatic sample_t scale_clamp(acc_t a);
    acc_t s;
    s = a >>> FRAC_W;
    if (s > acc_t'(SMAX))      return sample_t'(SMAX);
    else if (s < acc_t'(SMIN)) return sample_t'(SMIN);
    else                       return sample_t'(s[DATA_W-1:0]);
  endfunction
endpackage

// File: rtl/bq_history.sv
module bq_history
  import biquad_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    shift_en,
  input  sample_t din,
  output sample_t taps [DEPTH]
);
  localparam int VEC_W = DEPTH * DATA_W;

  logic [VEC_W-1:0] sr;

  generate
    if (DEPTH > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= {sr[VEC_W-DATA_W-1:0], din};
      end
      // older taps take the previous younger taps (R1 shift order)
      assert_shift_order_R1: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr[VEC_W-1:DATA_W] == $past(sr[VEC_W-DATA_W-1:0]));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= din;
      end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      assign taps[i] = sr[i*DATA_W +: DATA_W];
    end
  endgenerate

  assert_newest_tap_R1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sr[DATA_W-1:0] == $past(din));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr));
endmodule

// File: rtl/bq_section.sv
module bq_section
  import biquad_pkg::*;
#(
  parameter int B0 = 88,
  parameter int B1 = 176,
  parameter int B2 = 88,
  parameter int A1 = -28286,
  parameter int A2 = 12253
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t x0,
  input  sample_t x1,
  input  sample_t x2,
  input  sample_t yp1,
  input  sample_t yp2,
  output sample_t y
);
  acc_t p_b0, p_b1, p_b2, p_a1, p_a2, acc;

  always_comb begin
    p_b0 = acc_t'(B0) * acc_t'(x0);
    p_b1 = acc_t'(B1) * acc_t'(x1);
    p_b2 = acc_t'(B2) * acc_t'(x2);
    p_a1 = acc_t'(A1) * acc_t'(yp1);
    p_a2 = acc_t'(A2) * acc_t'(yp2);
    // feedback terms are subtracted (R1, R2)
    acc  = p_b0 + p_b1 + p_b2 - p_a1 - p_a2;
    y    = scale_clamp(acc);
  end

  assert_zero_rest_R8: assert property (@(posedge clk) disable iff (rst)
    (x0 == 0 && x1 == 0 && x2 == 0 && yp1 == 0 && yp2 == 0) |-> y == 0);
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int S1_B0 = 88,
  parameter int S1_B1 = 176,
  parameter int S1_B2 = 88,
  parameter int S1_A1 = -28286,
  parameter int S1_A2 = 12253,
  parameter int S2_B0 = 95,
  parameter int S2_B1 = 190,
  parameter int S2_B2 = 95,
  parameter int S2_A1 = -30541,
  parameter int S2_A2 = 14537
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic                   out_valid,
  output logic signed [15:0]     out_sample
);
  localparam int EXT_W = DATA_W - IN_W;

  sample_t x_ext, y1, y2;
  sample_t x_taps [2];
  sample_t u_taps [3];
  sample_t w_taps [2];
  logic    v1;

  assign x_ext = {{EXT_W{in_sample[IN_W-1]}}, in_sample};

  // input history: x[n-1], x[n-2]
  bq_history #(.DEPTH(2)) u_xhist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(x_ext), .taps(x_taps));

  bq_section #(.B0(S1_B0), .B1(S1_B1), .B2(S1_B2), .A1(S1_A1), .A2(S1_A2)) u_sec1 (
    .clk(clk), .rst(rst),
    .x0(x_ext), .x1(x_taps[0]), .x2(x_taps[1]),
    .yp1(u_taps[0]), .yp2(u_taps[1]), .y(y1));

  // shared history: output of section one, input of section two
  bq_history #(.DEPTH(3)) u_uhist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(y1), .taps(u_taps));

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  bq_section #(.B0(S2_B0), .B1(S2_B1), .B2(S2_B2), .A1(S2_A1), .A2(S2_A2)) u_sec2 (
    .clk(clk), .rst(rst),
    .x0(u_taps[0]), .x1(u_taps[1]), .x2(u_taps[2]),
    .yp1(w_taps[0]), .yp2(w_taps[1]), .y(y2));

  bq_history #(.DEPTH(2)) u_whist (
    .clk(clk), .rst(rst), .shift_en(v1), .din(y2), .taps(w_taps));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_sample <= y2;
    end
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_out_matches_history_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sample == w_taps[0]);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample));
endmodule

// File: tb/biquad_cascade_bench.sv
module biquad_cascade_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, in_valid;
  logic signed [11:0] in_sample;
  logic ov_a, ov_b;
  logic signed [15:0] os_a, os_b;

  biquad_cascade u_biquad_cascade (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_a), .out_sample(os_a));

  // high-gain build to drive both sections into the clamp
  biquad_cascade #(.S1_B0(8800), .S1_B1(17600), .S1_B2(8800)) u_biquad_cascade_hot (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(ov_b), .out_sample(os_b));

  int checks = 0, errors = 0, tick = 0;
  bit done = 0;
  longint mx1[2], mx2[2], u0[2], u1[2], w1[2], w2[2], last_out[2];
  int due_q[$];
  longint exp_a[$], exp_b[$];
  int unsigned seed = 32'h1234_5678;

  function automatic longint sect(longint b0, longint b1, longint b2, longint a1, longint a2,
                                  longint x0, longint x1, longint x2, longint p1, longint p2);
    longint acc, s;
    acc = b0*x0 + b1*x1 + b2*x2 - a1*p1 - a2*p2;
    s = acc >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic longint model(int d, longint x);
    longint g, y1, y2;
    g = (d == 0) ? 1 : 100;
    y1 = sect(88*g, 176*g, 88*g, -28286, 12253, x, mx1[d], mx2[d], u0[d], u1[d]);
    y2 = sect(95, 190, 95, -30541, 14537, y1, u0[d], u1[d], w1[d], w2[d]);
    mx2[d] = mx1[d]; mx1[d] = x;
    u1[d] = u0[d];   u0[d] = y1;
    w2[d] = w1[d];   w1[d] = y2;
    return y2;
  endfunction

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, tick);
    end
  endtask

  // one clock: check outputs at the falling edge, then drive the next input
  task automatic step(bit v, int s);
    bit ev;
    @(negedge clk);
    tick++;
    ev = (due_q.size() > 0) && (due_q[0] == tick);
    if (ev) begin
      void'(due_q.pop_front());
      last_out[0] = exp_a.pop_front();
      last_out[1] = exp_b.pop_front();
    end
    chk(ov_a == ev, "R5 valid timing", ov_a, ev);
    chk(ov_b == ev, "R5 valid timing (hot)", ov_b, ev);
    chk(os_a == last_out[0], "R1 R2 R3 R6 R9 data", os_a, last_out[0]);
    chk(os_b == last_out[1], "R4 R6 data (hot)", os_b, last_out[1]);
    in_valid = v;
    in_sample = 12'(s);
    if (v) begin
      due_q.push_back(tick + 2);
      exp_a.push_back(model(0, s));
      exp_b.push_back(model(1, s));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_sample = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int d = 0; d < 2; d++) begin
      mx1[d] = 0; mx2[d] = 0; u0[d] = 0; u1[d] = 0; w1[d] = 0; w2[d] = 0; last_out[d] = 0;
    end
    due_q.delete(); exp_a.delete(); exp_b.delete();
    chk(ov_a == 0, "R7 reset valid", ov_a, 0);
    chk(os_a == 0, "R7 reset sample", os_a, 0);
    chk(ov_b == 0, "R7 reset valid (hot)", ov_b, 0);
    chk(os_b == 0, "R7 reset sample (hot)", os_b, 0);
  endtask

  initial begin
    bit seen_pos, seen_neg;
    rst = 1; in_valid = 0; in_sample = '0;
    do_reset();

    // R8: zero input keeps output at zero
    for (int i = 0; i < 16; i++) begin
      step(1, 0);
      chk(os_a == 0, "R8 zero in zero out", os_a, 0);
    end
    // impulse response, R1 R2 R3
    step(1, 2047);
    for (int i = 0; i < 40; i++) step(1, 0);
    // negative full-scale step, R9 sign extension
    for (int i = 0; i < 60; i++) step(1, -2048);
    // alternating full scale
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? -2048 : 2047);
    // pseudo-random data with idle gaps, R6
    for (int i = 0; i < 150; i++) begin
      int unsigned r;
      r = rnd();
      step((r % 3) != 0, int'(r >> 8) % 4096 - 2048);
    end
    step(0, 0); step(0, 0);

    // R7: mid-run reset must clear all histories
    do_reset();
    step(1, -1000);
    for (int i = 0; i < 30; i++) step(1, 0);

    // R4: drive the high-gain build into saturation both ways
    seen_pos = 0; seen_neg = 0;
    for (int i = 0; i < 120; i++) begin
      step(1, 2047);
      if (os_b == 16'sd32767) seen_pos = 1;
    end
    for (int i = 0; i < 120; i++) begin
      step(1, -2048);
      if (os_b == -16'sd32768) seen_neg = 1;
    end
    chk(seen_pos, "R4 positive clamp reached", seen_pos, 1);
    chk(seen_neg, "R4 negative clamp reached", seen_neg, 1);
    for (int i = 0; i < 4; i++) step(0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule